// File: doc/BRIEF.md
# Converter serial result output port

This block moves a 16-bit conversion result onto one serial data line. The converter core is not modelled here. It is stood in for by a result word and two strobes: one marks the start of a conversion and one marks that it has finished. Every finished result is captured in a result register. At the start of each frame, the block copies that register, after the selected output coding is applied, into a shift register. It then sends the word most significant bit first.

In master mode the block makes its own data clock, one bit period per `CLK_DIV` system clocks, and drives a frame sync with selectable polarity. A read-mode input selects the start event for each frame:
- In the first read mode, the frame follows the end of conversion and carries the new result.
- In the second read mode, the frame follows the start of conversion and carries the result that was already held.

In slave mode a host clocks the data out through `ext_sclk`, qualified by `cs_n`. Both signals are resynchronised to `clk`. Bits arriving on `chain_in` follow the local word, so several ports can share one data line.

A single state machine controls the transfer:
- In `ST_IDLE` the port waits.
- `ST_IDLE -> ST_MSHIFT` occurs on a master start event.
- `ST_MSHIFT -> ST_IDLE` occurs after the last phase of bit 15.
- `ST_IDLE -> ST_SACTIVE` occurs when slave mode is selected and the synchronised `cs_n` is low.
- `ST_SACTIVE -> ST_IDLE` occurs when `cs_n` rises or slave mode is left.

Top module: `ser_result_port`

## Requirements
- R1: After reset `sdo` is 0, `sync_out` sits at its inactive level (equal to `sync_inv`), and `sclk_out` sits at its idle level, which is the inverse of `clk_inv`.
- R2: The mode is set by `slave_sel`. With `slave_sel` low, `cs_n` and `ext_sclk` have no effect. With `slave_sel` high, `sclk_out` stays idle, `sync_out` stays inactive, and data moves only on `ext_sclk` while `cs_n` is low.
- R3: Each frame sends the word loaded from the result register, most significant bit first, one bit per data-clock period.
- R4: `result` is taken as offset binary. With `fmt_twos` at 0 the word is sent unchanged. With `fmt_twos` at 1, bit 15 is inverted, which gives two's complement.
- R5: In master mode `sync_out` is active-high when `sync_inv` is 0 and active-low when `sync_inv` is 1.
- R6: In master mode `sync_out` becomes active when a frame starts. It stays active for exactly 16*`CLK_DIV` system clocks, which is 16 data-clock periods.
- R7: `clk_inv` at 0 makes the rising data-clock edge the edge on which data changes. `clk_inv` at 1 makes it the falling edge. This holds for `sclk_out` in master mode and for `ext_sclk` in slave mode, and receivers sample on the opposite edge.
- R8: The master data clock has a period of `CLK_DIV` system clocks. It gives exactly 16 sampling edges per frame and then returns to its idle level.
- R9: In master mode with `read_prev` at 0, a frame starts one cycle after `conv_done` and `conv_start` starts nothing. With `read_prev` at 1, a frame starts on `conv_start` and carries the result held before that conversion.
- R10: In slave mode, the bit on `chain_in` at each sampling edge appears on `sdo` 16 data-clock periods later, after the local word.
- R11: In slave mode, raising `cs_n` during a frame stops shifting and `sdo` holds its value. Lowering `cs_n` again restarts the frame from the MSB of the held result.
- R12: A result that arrives during a frame does not change that frame. It is sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_sel | input | 1 | 0: master clocking, 1: slave clocking |
| sync_inv | input | 1 | 0: active-high sync, 1: active-low sync |
| clk_inv | input | 1 | 0: data changes on rising edge, 1: on falling edge |
| read_prev | input | 1 | Master read mode: 0 after conversion, 1 during conversion |
| fmt_twos | input | 1 | 0: offset binary, 1: two's complement |
| conv_start | input | 1 | One-cycle strobe for start of conversion |
| conv_done | input | 1 | One-cycle strobe: `result` is valid |
| result | input | DATA_W | Conversion result, offset binary |
| ext_sclk | input | 1 | External data clock in slave mode |
| cs_n | input | 1 | Active-low select in slave mode |
| chain_in | input | 1 | Serial input for the daisy chain |
| sdo | output | 1 | Serial data output |
| sclk_out | output | 1 | Master data clock |
| sync_out | output | 1 | Master frame sync |

## Verification
The hardest behaviour to reach from the ports is the slave restart. The host has to stop its clock partway through a word, raise `cs_n`, and keep toggling `ext_sclk` while deselected. It must then lower `cs_n` again and confirm that the whole word comes back from the MSB.

The stimulus does this by driving the external clock from a task. The task reads five bits, releases select, and toggles the clock three times. The output must not move during those toggles. The task then performs a full read.

A second awkward case is a result that arrives in the middle of a frame. The bench produces it by placing a `conv_done` pulse twenty cycles into a read-during-convert frame. It then expects the old word in that frame and the new word in the next one.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MSHIFT  = 2'd1,
        ST_SACTIVE = 2'd2
    } port_state_e;

endpackage

// File: rtl/ser_port_edge.sv
// Resynchronises an asynchronous level and flags its edges.
module ser_port_edge #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] pipe;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe   <= {STAGES{INIT}};
            last_q <= INIT;
        end else begin
            pipe   <= {pipe[STAGES-2:0], din};
            last_q <= pipe[STAGES-1];
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~last_q;
    assign fall  = ~pipe[STAGES-1] & last_q;

endmodule

// File: rtl/ser_port_shreg.sv
// Parallel-load, MSB-first shift register.
module ser_port_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic         msb
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], shift_in};
        end
    end

    assign msb = sr_q[W-1];

endmodule

// File: rtl/ser_port_clkdiv.sv
// Phase counter for the master data clock, one bit period = DIV clocks.
module ser_port_clkdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last_phase,
    output logic high_half
);

    localparam int            CW    = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF  = CW'(DIV / 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_phase = run && (cnt_q == LAST);
    assign high_half  = run && (cnt_q >= HALF);

endmodule

// File: rtl/ser_result_port.sv
module ser_result_port
    import ser_port_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_sel,
    input  logic              sync_inv,
    input  logic              clk_inv,
    input  logic              read_prev,
    input  logic              fmt_twos,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result,
    input  logic              ext_sclk,
    input  logic              cs_n,
    input  logic              chain_in,
    output logic              sdo,
    output logic              sclk_out,
    output logic              sync_out
);

    localparam int            BW       = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    port_state_e       state_q, state_n;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] load_word;
    logic [BW-1:0]     bit_q;
    logic              done_q;
    logic              chain_q;
    logic              start_m;
    logic              sr_load, sr_shift, sr_in, sr_msb;
    logic              last_phase, high_half;
    logic              xs_level, xs_rise, xs_fall;
    logic              cs_level, cs_rise, cs_fall;
    logic              act_edge, smp_edge;

    // Result register: every finished conversion lands here (R12).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= conv_done;
            if (conv_done) begin
                res_q <= result;
            end
        end
    end

    // Offset binary to two's complement by flipping the top bit (R4).
    assign load_word = {res_q[DATA_W-1] ^ fmt_twos, res_q[DATA_W-2:0]};

    // Master start event (R9).
    assign start_m = ~slave_sel & (read_prev ? conv_start : done_q);

    ser_port_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_xs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_sclk),
        .level (xs_level),
        .rise  (xs_rise),
        .fall  (xs_fall)
    );

    ser_port_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cs_n),
        .level (cs_level),
        .rise  (cs_rise),
        .fall  (cs_fall)
    );

    assign act_edge = clk_inv ? xs_fall : xs_rise;
    assign smp_edge = clk_inv ? xs_rise : xs_fall;

    ser_port_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state_q == ST_MSHIFT),
        .last_phase (last_phase),
        .high_half  (high_half)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next-state logic.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!slave_sel && start_m) begin
                    state_n = ST_MSHIFT;
                end else if (slave_sel && !cs_level) begin
                    state_n = ST_SACTIVE;
                end
            end
            ST_MSHIFT: begin
                if (last_phase && bit_q == LAST_BIT) begin
                    state_n = ST_IDLE;
                end
            end
            ST_SACTIVE: begin
                if (cs_level || !slave_sel) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Shift control.
    always_comb begin
        sr_load  = (state_q == ST_IDLE) && (state_n != ST_IDLE);
        sr_shift = ((state_q == ST_MSHIFT) && last_phase && (bit_q != LAST_BIT))
                || ((state_q == ST_SACTIVE) && (state_n == ST_SACTIVE) && act_edge);
        sr_in    = (state_q == ST_SACTIVE) ? chain_q : 1'b0;
    end

    // Bit counter (master) and daisy-chain capture on the sampling edge (R10).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            chain_q <= 1'b0;
        end else begin
            if (sr_load) begin
                bit_q <= '0;
            end else if (sr_shift && state_q == ST_MSHIFT) begin
                bit_q <= bit_q + 1'b1;
            end
            if (state_q == ST_SACTIVE && smp_edge) begin
                chain_q <= chain_in;
            end
        end
    end

    ser_port_shreg #(.W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sr_load),
        .load_val (load_word),
        .shift    (sr_shift),
        .shift_in (sr_in),
        .msb      (sr_msb)
    );

    // Outputs.
    always_comb begin
        sdo      = sr_msb;
        sclk_out = ~clk_inv ^ ((state_q == ST_MSHIFT) && high_half);
        sync_out = (state_q == ST_MSHIFT) ? ~sync_inv : sync_inv;
    end

    // Level and cs edges are resynchronised for completeness; unused copies tied off.
    logic unused_ok;
    assign unused_ok = &{1'b0, xs_level, cs_rise, cs_fall};

endmodule

// File: rtl/ser_result_port_chk.sv
module ser_result_port_chk #(
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic slave_sel,
    input logic sync_inv,
    input logic clk_inv,
    input logic cs_n,
    input logic sdo,
    input logic sclk_out,
    input logic sync_out
);

    localparam int FRAME_CYC = DATA_W * CLK_DIV;
    localparam int CS_QUIET  = SYNC_STAGES + 2;

    logic sync_act;
    logic prev_act, prev_sdo, prev_sclk;
    int   act_run;
    int   hi_cnt;

    assign sync_act = (sync_out != sync_inv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_act  <= 1'b0;
            prev_sdo  <= 1'b0;
            prev_sclk <= 1'b1;
            act_run   <= 0;
            hi_cnt    <= 0;
        end else begin
            prev_act  <= sync_act;
            prev_sdo  <= sdo;
            prev_sclk <= sclk_out;
            act_run   <= sync_act ? act_run + 1 : 0;
            if (!cs_n) begin
                hi_cnt <= 0;
            end else if (hi_cnt < 1000) begin
                hi_cnt <= hi_cnt + 1;
            end
        end
    end

    assert_sync_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_act && !sync_act && $stable(sync_inv)) |-> (act_run == FRAME_CYC));

    assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_act) |-> (sclk_out == !clk_inv));

    assert_slave_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_sel && !prev_act) |-> !sync_act);

    assert_sdo_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_act && prev_act && (sdo != prev_sdo) && $stable(clk_inv))
        |-> ((sclk_out == !clk_inv) && (prev_sclk != sclk_out)));

    assert_cs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(slave_sel) && slave_sel && ($past(hi_cnt) >= CS_QUIET)) |-> $stable(sdo));

endmodule

bind ser_result_port ser_result_port_chk #(
    .DATA_W      (DATA_W),
    .CLK_DIV     (CLK_DIV),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_sel (slave_sel),
    .sync_inv  (sync_inv),
    .clk_inv   (clk_inv),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .sclk_out  (sclk_out),
    .sync_out  (sync_out)
);

// File: tb/ser_result_port_tb_top.sv
module ser_result_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int DIV        = 4;
    localparam int FRAME      = DW * DIV;
    localparam int HALF_EXT   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_sel = 1'b0, sync_inv = 1'b0, clk_inv = 1'b0;
    logic          read_prev = 1'b0, fmt_twos = 1'b0;
    logic          conv_start = 1'b0, conv_done = 1'b0;
    logic [DW-1:0] result = '0;
    logic          ext_sclk = 1'b1, cs_n = 1'b1, chain_in = 1'b0;
    logic          sdo, sclk_out, sync_out;

    int  n_checks = 0;
    int  n_errors = 0;
    int  frames_seen = 0;
    bit  finished = 1'b0;

    typedef struct {
        logic [DW-1:0] w;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ser_result_port #(.DATA_W(DW), .CLK_DIV(DIV)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_sel  (slave_sel),
        .sync_inv   (sync_inv),
        .clk_inv    (clk_inv),
        .read_prev  (read_prev),
        .fmt_twos   (fmt_twos),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .result     (result),
        .ext_sclk   (ext_sclk),
        .cs_n       (cs_n),
        .chain_in   (chain_in),
        .sdo        (sdo),
        .sclk_out   (sclk_out),
        .sync_out   (sync_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] coded(input logic [DW-1:0] w, input logic twos);
        return {w[DW-1] ^ twos, w[DW-2:0]};
    endfunction

    // Monitor: master-mode receiver, compares against the scoreboard queue.
    initial begin
        bit            in_frame = 1'b0;
        int            width = 0, nbits = 0, bad = 0;
        logic [DW-1:0] word = '0;
        logic          prev_sclk = 1'b1, prev_sdo = 1'b0;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (sync_out != sync_inv) begin
                if (!in_frame) begin
                    in_frame  = 1'b1;
                    width     = 0;
                    nbits     = 0;
                    bad       = 0;
                    word      = '0;
                    prev_sclk = sclk_out;
                    prev_sdo  = sdo;
                end
                width++;
                if (prev_sclk != sclk_out && sclk_out == clk_inv) begin
                    word = {word[DW-2:0], sdo};
                    nbits++;
                end
                if (width > 1 && sdo != prev_sdo &&
                    !(sclk_out == !clk_inv && prev_sclk != sclk_out)) begin
                    bad++;
                end
                prev_sclk = sclk_out;
                prev_sdo  = sdo;
            end else if (in_frame) begin
                in_frame = 1'b0;
                frames_seen++;
                check(width == FRAME, "R6", "sync active width", width, FRAME);
                check(nbits == DW, "R8", "sampling edges per frame", nbits, DW);
                check(bad == 0, "R7", "sdo changes off the active edge", bad, 0);
                check(sclk_out == !clk_inv, "R8", "sclk idle after frame", sclk_out, !clk_inv);
                check(sync_out == sync_inv, "R5", "sync inactive level", sync_out, sync_inv);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected frame", word, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(word == e.w, e.tag, "frame word", word, e.w);
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) conv_start = 1'b1;
        @(negedge clk) conv_start = 1'b0;
    endtask

    task automatic pulse_done(input logic [DW-1:0] w);
        @(negedge clk) begin result = w; conv_done = 1'b1; end
        @(negedge clk) conv_done = 1'b0;
    endtask

    // Driver: sets configuration, pushes expected word, runs one conversion.
    task automatic master_after_done(input logic si, input logic ci, input logic ft,
                                     input logic [DW-1:0] w, input string tag);
        exp_t e;
        @(negedge clk) begin sync_inv = si; clk_inv = ci; fmt_twos = ft; read_prev = 1'b0; end
        repeat (4) @(negedge clk);
        check(sync_out == si, "R5", "idle sync level", sync_out, si);
        check(sclk_out == !ci, "R7", "idle sclk level", sclk_out, !ci);
        e.w = coded(w, ft);
        e.tag = tag;
        exp_q.push_back(e);
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_done(w);
        repeat (FRAME + 12) @(negedge clk);
    endtask

    task automatic slave_read(input int nbits, input logic [DW-1:0] cw,
                              output logic [31:0] got, output bit quiet_ok);
        logic act_lvl;
        act_lvl  = !clk_inv;
        got      = '0;
        quiet_ok = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            chain_in = cw[DW-1-(i % DW)];
            repeat (HALF_EXT) @(negedge clk);
            got = {got[30:0], sdo};
            if (sclk_out != !clk_inv || sync_out != sync_inv) quiet_ok = 1'b0;
            ext_sclk = ~act_lvl;
            repeat (HALF_EXT) @(negedge clk);
            ext_sclk = act_lvl;
        end
    endtask

    task automatic slave_setup(input logic ci, input logic ft, input logic [DW-1:0] w);
        @(negedge clk) begin slave_sel = 1'b1; clk_inv = ci; fmt_twos = ft; ext_sclk = !ci; end
        pulse_done(w);
        repeat (10) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        bit          quiet;
        int          f0;
        logic        held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(sdo == 1'b0, "R1", "sdo after reset", sdo, 0);
        check(sync_out == 1'b0, "R1", "sync after reset", sync_out, 0);
        check(sclk_out == 1'b1, "R1", "sclk after reset", sclk_out, 1);

        // Master, read after conversion, all polarity/edge combos (R3 R4 R5 R7)
        master_after_done(1'b0, 1'b0, 1'b0, 16'hA5C3, "R3");
        master_after_done(1'b1, 1'b0, 1'b1, 16'h0001, "R4");
        master_after_done(1'b0, 1'b1, 1'b1, 16'hFFFE, "R4");
        master_after_done(1'b1, 1'b1, 1'b0, 16'h8000, "R5");

        // R9: conv_start alone starts nothing when read_prev is 0
        @(negedge clk) begin sync_inv = 1'b0; clk_inv = 1'b0; fmt_twos = 1'b0; end
        f0 = frames_seen;
        pulse_start();
        repeat (FRAME + 10) @(negedge clk);
        check(frames_seen == f0, "R9", "frames after start only", frames_seen, f0);

        // R2: master ignores cs_n and ext_sclk
        f0 = frames_seen;
        held = sdo;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) begin cs_n = k[0]; ext_sclk = ~ext_sclk; end
            repeat (6) @(negedge clk);
        end
        cs_n = 1'b1;
        check(frames_seen == f0, "R2", "master frames from cs_n", frames_seen, f0);
        check(sdo == held, "R2", "master sdo under ext clock", sdo, held);

        // R9 / R12: read during conversion returns previous result
        begin
            exp_t e;
            @(negedge clk) read_prev = 1'b1;
            e.w = 16'h8000; e.tag = "R9";
            exp_q.push_back(e);
            pulse_start();
            repeat (20) @(negedge clk);
            pulse_done(16'h1234);
            repeat (FRAME) @(negedge clk);
            e.w = 16'h1234; e.tag = "R12";
            exp_q.push_back(e);
            pulse_start();
            repeat (20) @(negedge clk);
            pulse_done(16'h5555);
            repeat (FRAME) @(negedge clk);
            read_prev = 1'b0;
        end
        check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);

        // Slave mode, rising active edge, offset binary, daisy chain (R10)
        slave_setup(1'b0, 1'b0, 16'h3C5A);
        slave_read(32, 16'hF00D, got, quiet);
        @(negedge clk) cs_n = 1'b1;
        repeat (10) @(negedge clk);
        check(got[31:16] == 16'h3C5A, "R7", "slave local word rising", got[31:16], 16'h3C5A);
        check(got[15:0] == 16'hF00D, "R10", "daisy word rising", got[15:0], 16'hF00D);
        check(quiet, "R2", "slave keeps sclk idle and sync inactive", quiet, 1);

        // Slave mode, falling active edge, two's complement
        slave_setup(1'b1, 1'b1, 16'h7FFF);
        slave_read(32, 16'h0FF1, got, quiet);
        @(negedge clk) cs_n = 1'b1;
        repeat (10) @(negedge clk);
        check(got[31:16] == 16'hFFFF, "R4", "slave twos word falling", got[31:16], 16'hFFFF);
        check(got[15:0] == 16'h0FF1, "R10", "daisy word falling", got[15:0], 16'h0FF1);

        // R11: cs_n raised mid-frame, output holds, restart from MSB
        slave_setup(1'b0, 1'b0, 16'hC001);
        slave_read(5, 16'h0000, got, quiet);
        check(got[4:0] == 5'b11000, "R11", "partial read bits", got[4:0], 5'b11000);
        @(negedge clk) cs_n = 1'b1;
        repeat (6) @(negedge clk);
        held = sdo;
        for (int k = 0; k < 3; k++) begin
            ext_sclk = ~ext_sclk;
            repeat (HALF_EXT) @(negedge clk);
            ext_sclk = ~ext_sclk;
            repeat (HALF_EXT) @(negedge clk);
        end
        check(sdo == held, "R11", "sdo held while deselected", sdo, held);
        slave_read(16, 16'h0000, got, quiet);
        @(negedge clk) cs_n = 1'b1;
        repeat (10) @(negedge clk);
        check(got[15:0] == 16'hC001, "R11", "restart from MSB", got[15:0], 16'hC001);

        @(negedge clk) slave_sel = 1'b0;
        repeat (10) @(negedge clk);
        check(frames_seen == 6, "R3", "master frame count", frames_seen, 6);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule